// File: doc/BRIEF.md
# Microcoded Pattern Bus Sequencer

This block drives an external bus from a small table of control words that software loads at run time. Each word states, for one bus clock, the four quarter-cycle phases of a chip-select strobe and of a byte-select strobe, the levels of six general-purpose lines, a capture flag that latches the incoming data bus, and a final-word flag that closes the pattern. A read request steps the table from one fixed entry and a write request from another. The timing of every strobe comes from the table, not from a hard-wired state machine.

Programming goes through two registers. The mode register holds a two-bit command code, a wait-enable bit, a read-after-write bit and the table pointer. The data register holds the word to be stored. A command strobe with the code set to program copies the data register into the table at the pointer, and the pointer then advances by one. General-purpose line 4 can be turned into an active-high wait input that freezes the running pattern. With the read-after-write bit set, a write pattern is followed at once by a read pattern. This suits a search port where a key is written in and the result is read straight back. The top bit of the returned word carries a miss flag.

Top module: `pattern_bus_seq`

## Requirements
- R1: After reset the block is idle, with busy and done low. The chip-select and byte-select phase outputs are all ones, the general-purpose outputs are all ones, the table pointer is 0 and the result-valid flag is low. While idle, all these strobe outputs stay at all ones.
- R2: A command strobe stores the data register into the table only when the mode register code is 2'b01 (program). With code 2'b00 (normal) the strobe changes neither the table nor the pointer. The data register loads one cycle before it can be stored.
- R3: Each stored word advances the table pointer by one, and the pointer wraps from 63 to 0. A mode register load replaces the pointer.
- R4: A read request taken while idle starts the pattern at table entry 0. A write request starts it at entry 24. Each takes effect at the edge that samples it. From then on one word drives the outputs per clock, in table order. A word is a 16-bit value: bits 3:0 hold the chip-select phases, bits 7:4 the byte-select phases, bits 13:8 general-purpose lines 5 to 0, bit 14 the capture flag and bit 15 the final-word flag.
- R5: When wait-enable is set and the wait input is high at an edge, the pattern does not advance. The current word, including a final word, stays on the outputs. While wait-enable is set, general-purpose output 4 is forced high.
- R6: At the edge where a final word advances, the pattern ends. Done pulses for exactly one cycle, and the done-kind output is 1 for a write pattern and 0 for a read pattern. Busy falls unless another pattern starts at that same edge.
- R7: A request that arrives while a pattern runs is held. It starts at the edge where the current pattern ends, with no idle cycle between the two. When a read request and a write request are both waiting, the write starts first.
- R8: With the read-after-write bit set, the end of a write pattern starts the read pattern at the same edge, ahead of any held request.
- R9: When a word with the capture flag advances, the data bus is latched into the result register. Result-valid pulses for the following cycle. The hit output is set when bit 31 of the latched word is 0. A word that is stalled by wait does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wr_i | input | 1 | Load all mode register fields |
| mode_op_i | input | 2 | Command code: 00 normal, 01 program |
| mode_wait_en_i | input | 1 | Turn general-purpose line 4 into a wait input |
| mode_atomic_i | input | 1 | Read-after-write enable |
| mode_mad_i | input | 6 | Table pointer value to load |
| dreg_wr_i | input | 1 | Load the data register |
| dreg_d_i | input | 16 | Data register value |
| cmd_i | input | 1 | Command strobe (store word when programming) |
| start_rd_i | input | 1 | Read pattern request |
| start_wr_i | input | 1 | Write pattern request |
| wait_i | input | 1 | Active-high wait from the external pin |
| bus_data_i | input | 32 | Returned data bus |
| cs_o | output | 4 | Chip-select quarter-cycle phases |
| bs_o | output | 4 | Byte-select quarter-cycle phases |
| gpl_o | output | 6 | General-purpose line levels |
| busy_o | output | 1 | A pattern is running |
| done_o | output | 1 | One-cycle end-of-pattern pulse |
| done_wr_o | output | 1 | Kind of the pattern that ended (1 = write) |
| mad_o | output | 6 | Current table pointer |
| res_data_o | output | 32 | Latched result word |
| res_valid_o | output | 1 | One-cycle pulse after a capture |
| res_hit_o | output | 1 | Hit flag of the latched result |

## Verification
The bench holds the wait input high on a plain word, on the capture word and on the final word. A sequencer that let wait slip would move the byte-select sequence early, capture twice or too soon, or pulse done while the final word is still frozen. It posts read and write requests together in the middle of a running read. A design that drops held requests, lets read win, or leaves an idle gap would show a wrong chip-select phase on the edge where the first pattern ends. With read-after-write enabled it checks that the chained read comes before a held write. It also checks that pointer wrap and normal-mode command strobes leave the loaded table as it was.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int CS_PH = 4;
  localparam int BS_PH = 4;
  localparam int GPL_N = 6;
  localparam int GPL_WAIT_IDX = 4;

  typedef struct packed {
    logic             last;
    logic             smp;
    logic [GPL_N-1:0] gpl;
    logic [BS_PH-1:0] bs;
    logic [CS_PH-1:0] cs;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);

  localparam logic [1:0] OP_NORMAL = 2'b00;
  localparam logic [1:0] OP_PROG   = 2'b01;

  typedef enum logic {KIND_RD = 1'b0, KIND_WR = 1'b1} kind_e;
endpackage

// File: rtl/pbs_regs.sv
module pbs_regs import pbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_i,
  input  logic [1:0]        mode_op_i,
  input  logic              mode_wait_en_i,
  input  logic              mode_atomic_i,
  input  logic [ADDR_W-1:0] mode_mad_i,
  input  logic              dreg_wr_i,
  input  logic [WORD_W-1:0] dreg_d_i,
  input  logic              cmd_i,
  output logic              wait_en_o,
  output logic              atomic_o,
  output logic [ADDR_W-1:0] mad_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic [WORD_W-1:0] ram_wdata_o
);
  logic [1:0]        op_q, op_d;
  logic              wen_q, wen_d, atom_q, atom_d;
  logic [ADDR_W-1:0] mad_q, mad_d;
  logic [WORD_W-1:0] dreg_q, dreg_d;
  logic              prog_fire;

  always_comb begin
    prog_fire = cmd_i && (op_q == OP_PROG);
    op_d   = op_q;
    wen_d  = wen_q;
    atom_d = atom_q;
    mad_d  = mad_q;
    dreg_d = dreg_q;
    if (mode_wr_i) begin
      op_d   = mode_op_i;
      wen_d  = mode_wait_en_i;
      atom_d = mode_atomic_i;
      mad_d  = mode_mad_i;
    end else if (prog_fire) begin
      mad_d = mad_q + 1'b1;
    end
    if (dreg_wr_i) dreg_d = dreg_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NORMAL;
      wen_q  <= 1'b0;
      atom_q <= 1'b0;
      mad_q  <= '0;
      dreg_q <= '0;
    end else begin
      op_q   <= op_d;
      wen_q  <= wen_d;
      atom_q <= atom_d;
      mad_q  <= mad_d;
      dreg_q <= dreg_d;
    end
  end

  assign wait_en_o   = wen_q;
  assign atomic_o    = atom_q;
  assign mad_o       = mad_q;
  assign ram_we_o    = prog_fire;
  assign ram_waddr_o = mad_q;
  assign ram_wdata_o = dreg_q;

  // R3: a stored word moves the pointer on by one (wrapping)
  p_mad_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i && op_q == OP_PROG && !mode_wr_i) |=> (mad_q == $past(mad_q) + 1'b1));

  // R2: in normal mode a command strobe leaves the pointer alone
  p_normal_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i && op_q == OP_NORMAL && !mode_wr_i) |=> $stable(mad_q));
endmodule

// File: rtl/pbs_uram.sv
module pbs_uram #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/pbs_seq.sv
module pbs_seq import pbs_pkg::*; #(
  parameter int ADDR_W  = 6,
  parameter int RD_BASE = 0,
  parameter int WR_BASE = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd_i,
  input  logic              start_wr_i,
  input  logic              wait_i,
  input  logic              wait_en_i,
  input  logic              atomic_i,
  input  logic              last_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              adv_o,
  output logic              done_o,
  output logic              done_wr_o
);
  localparam logic [ADDR_W-1:0] RD_PTR = ADDR_W'(RD_BASE);
  localparam logic [ADDR_W-1:0] WR_PTR = ADDR_W'(WR_BASE);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  kind_e             kind_q, kind_d;
  logic              pend_rd_q, pend_rd_d, pend_wr_q, pend_wr_d;
  logic              done_q, done_d;
  kind_e             dkind_q, dkind_d;
  logic              stall, adv, ending, chain, free, req_rd, req_wr;

  always_comb begin
    stall  = busy_q && wait_en_i && wait_i;
    adv    = busy_q && !stall;
    ending = adv && last_i;
    chain  = ending && (kind_q == KIND_WR) && atomic_i;
    free   = !busy_q || ending;
    req_rd = pend_rd_q || start_rd_i;
    req_wr = pend_wr_q || start_wr_i;

    busy_d    = busy_q;
    ptr_d     = adv ? ptr_q + 1'b1 : ptr_q;
    kind_d    = kind_q;
    pend_rd_d = req_rd;
    pend_wr_d = req_wr;
    done_d    = ending;
    dkind_d   = ending ? kind_q : dkind_q;

    if (free) begin
      busy_d = 1'b0;
      if (chain) begin
        busy_d = 1'b1;
        ptr_d  = RD_PTR;
        kind_d = KIND_RD;
      end else if (req_wr) begin
        busy_d    = 1'b1;
        ptr_d     = WR_PTR;
        kind_d    = KIND_WR;
        pend_wr_d = 1'b0;
      end else if (req_rd) begin
        busy_d    = 1'b1;
        ptr_d     = RD_PTR;
        kind_d    = KIND_RD;
        pend_rd_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      ptr_q     <= '0;
      kind_q    <= KIND_RD;
      pend_rd_q <= 1'b0;
      pend_wr_q <= 1'b0;
      done_q    <= 1'b0;
      dkind_q   <= KIND_RD;
    end else begin
      busy_q    <= busy_d;
      ptr_q     <= ptr_d;
      kind_q    <= kind_d;
      pend_rd_q <= pend_rd_d;
      pend_wr_q <= pend_wr_d;
      done_q    <= done_d;
      dkind_q   <= dkind_d;
    end
  end

  assign busy_o    = busy_q;
  assign ptr_o     = ptr_q;
  assign adv_o     = adv;
  assign done_o    = done_q;
  assign done_wr_o = (dkind_q == KIND_WR);

  // R5: a stalled pattern keeps its word and stays running
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wait_en_i && wait_i) |=> (busy_q && $stable(ptr_q) && $stable(kind_q)));

  // R4: a write request taken while idle lands on the write entry
  p_wr_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_wr_i) |=> (busy_q && kind_q == KIND_WR && ptr_q == WR_PTR));

  // R4: a lone read request taken while idle lands on the read entry
  p_rd_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_rd_i && !start_wr_i) |=> (busy_q && kind_q == KIND_RD && ptr_q == RD_PTR));

  // R6: done only follows a running pattern and lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !$past(done_q)));

  // R8: the end of a write with read-after-write chains the read
  p_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !stall && last_i && kind_q == KIND_WR && atomic_i)
      |=> (busy_q && kind_q == KIND_RD && ptr_q == RD_PTR));
endmodule

// File: rtl/pbs_capture.sv
module pbs_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_valid_o,
  output logic              res_hit_o
);
  logic [DATA_W-1:0] res_q, res_d;
  logic              vld_q, hit_q, hit_d;

  always_comb begin
    res_d = take_i ? data_i : res_q;
    hit_d = take_i ? ~data_i[DATA_W-1] : hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= take_i;
      hit_q <= hit_d;
    end
  end

  assign res_data_o  = res_q;
  assign res_valid_o = vld_q;
  assign res_hit_o   = hit_q;

  // R9: a capture shows up the next cycle with the sampled bus value
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (res_valid_o && res_data_o == $past(data_i)));
endmodule

// File: rtl/pattern_bus_seq.sv
module pattern_bus_seq import pbs_pkg::*; #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int RD_BASE = 0,
  parameter int WR_BASE = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr_i,
  input  logic [1:0]         mode_op_i,
  input  logic               mode_wait_en_i,
  input  logic               mode_atomic_i,
  input  logic [ADDR_W-1:0]  mode_mad_i,
  input  logic               dreg_wr_i,
  input  logic [UWORD_W-1:0] dreg_d_i,
  input  logic               cmd_i,
  input  logic               start_rd_i,
  input  logic               start_wr_i,
  input  logic               wait_i,
  input  logic [DATA_W-1:0]  bus_data_i,
  output logic [CS_PH-1:0]   cs_o,
  output logic [BS_PH-1:0]   bs_o,
  output logic [GPL_N-1:0]   gpl_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               done_wr_o,
  output logic [ADDR_W-1:0]  mad_o,
  output logic [DATA_W-1:0]  res_data_o,
  output logic               res_valid_o,
  output logic               res_hit_o
);
  logic               rst_meta_q, rst_sync_q;
  logic               wait_en, atomic, ram_we, busy, adv;
  logic [ADDR_W-1:0]  ram_waddr, ptr;
  logic [UWORD_W-1:0] ram_wdata, ram_rdata;
  uword_t             cur_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pbs_regs #(.ADDR_W(ADDR_W), .WORD_W(UWORD_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q),
    .mode_wr_i(mode_wr_i), .mode_op_i(mode_op_i),
    .mode_wait_en_i(mode_wait_en_i), .mode_atomic_i(mode_atomic_i),
    .mode_mad_i(mode_mad_i), .dreg_wr_i(dreg_wr_i), .dreg_d_i(dreg_d_i),
    .cmd_i(cmd_i), .wait_en_o(wait_en), .atomic_o(atomic), .mad_o(mad_o),
    .ram_we_o(ram_we), .ram_waddr_o(ram_waddr), .ram_wdata_o(ram_wdata)
  );

  pbs_uram #(.ADDR_W(ADDR_W), .WORD_W(UWORD_W)) u_uram (
    .clk(clk), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .raddr_i(ptr), .rdata_o(ram_rdata)
  );

  assign cur_w = uword_t'(ram_rdata);

  pbs_seq #(.ADDR_W(ADDR_W), .RD_BASE(RD_BASE), .WR_BASE(WR_BASE)) u_seq (
    .clk(clk), .rst_n(rst_sync_q),
    .start_rd_i(start_rd_i), .start_wr_i(start_wr_i),
    .wait_i(wait_i), .wait_en_i(wait_en), .atomic_i(atomic),
    .last_i(cur_w.last), .busy_o(busy), .ptr_o(ptr), .adv_o(adv),
    .done_o(done_o), .done_wr_o(done_wr_o)
  );

  pbs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_sync_q), .take_i(adv && cur_w.smp),
    .data_i(bus_data_i), .res_data_o(res_data_o),
    .res_valid_o(res_valid_o), .res_hit_o(res_hit_o)
  );

  always_comb begin
    cs_o  = '1;
    bs_o  = '1;
    gpl_o = '1;
    if (busy) begin
      cs_o  = cur_w.cs;
      bs_o  = cur_w.bs;
      gpl_o = cur_w.gpl;
    end
    if (wait_en) gpl_o[GPL_WAIT_IDX] = 1'b1;
  end

  assign busy_o = busy;

  // R1: an idle machine holds every strobe inactive
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy_o |-> (cs_o == '1 && bs_o == '1 && gpl_o == '1));

  // R5: in wait mode line 4 never drives low
  p_wait_pin_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wait_en |-> gpl_o[GPL_WAIT_IDX]);
endmodule

// File: tb/pattern_bus_seq_bench.sv
module pattern_bus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr_i = 0, mode_wait_en_i = 0, mode_atomic_i = 0;
  logic [1:0]  mode_op_i = 0;
  logic [5:0]  mode_mad_i = 0;
  logic        dreg_wr_i = 0, cmd_i = 0, start_rd_i = 0, start_wr_i = 0, wait_i = 0;
  logic [15:0] dreg_d_i = 0;
  logic [31:0] bus_data_i = 0;
  logic [3:0]  cs_o, bs_o;
  logic [5:0]  gpl_o, mad_o;
  logic        busy_o, done_o, done_wr_o, res_valid_o, res_hit_o;
  logic [31:0] res_data_o;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  pattern_bus_seq u_pattern_bus_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .mode_op_i(mode_op_i),
    .mode_wait_en_i(mode_wait_en_i), .mode_atomic_i(mode_atomic_i),
    .mode_mad_i(mode_mad_i), .dreg_wr_i(dreg_wr_i), .dreg_d_i(dreg_d_i),
    .cmd_i(cmd_i), .start_rd_i(start_rd_i), .start_wr_i(start_wr_i),
    .wait_i(wait_i), .bus_data_i(bus_data_i), .cs_o(cs_o), .bs_o(bs_o),
    .gpl_o(gpl_o), .busy_o(busy_o), .done_o(done_o), .done_wr_o(done_wr_o),
    .mad_o(mad_o), .res_data_o(res_data_o), .res_valid_o(res_valid_o),
    .res_hit_o(res_hit_o)
  );

  function automatic logic [15:0] mk(logic last, logic smp, logic [5:0] gpl,
                                     logic [3:0] bs, logic [3:0] cs);
    return {last, smp, gpl, bs, cs};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(logic [1:0] op, logic wen, logic atom, logic [5:0] mad);
    mode_op_i = op; mode_wait_en_i = wen; mode_atomic_i = atom; mode_mad_i = mad;
    mode_wr_i = 1; tick(); mode_wr_i = 0;
  endtask

  task automatic prog(logic [15:0] w);
    dreg_d_i = w; dreg_wr_i = 1; tick(); dreg_wr_i = 0;
    cmd_i = 1; tick(); cmd_i = 0;
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "cs", cs_o, 4'hF);
    chk("R1", "bs", bs_o, 4'hF);
    chk("R1", "gpl", gpl_o, 6'h3F);
    chk("R1", "mad", mad_o, 0);
    chk("R1", "res_valid", res_valid_o, 0);
  endtask

  task automatic t_program();
    set_mode(2'b01, 0, 0, 6'd0);
    prog(mk(0, 0, 6'h0F, 4'h1, 4'hF));
    prog(mk(0, 1, 6'h0F, 4'h2, 4'hF));
    prog(mk(1, 0, 6'h3F, 4'h3, 4'hF));
    chk("R3", "mad after 3 stores", mad_o, 6'd3);
    set_mode(2'b01, 0, 0, 6'd24);
    prog(mk(0, 0, 6'h3F, 4'hF, 4'h0));
    prog(mk(1, 0, 6'h3F, 4'hF, 4'hC));
    chk("R3", "mad after write entries", mad_o, 6'd26);
    set_mode(2'b01, 0, 0, 6'd63);
    prog(16'h1234);
    chk("R3", "mad wrap", mad_o, 6'd0);
    set_mode(2'b00, 0, 0, 6'd1);
    prog(mk(1, 0, 6'h00, 4'h9, 4'h9));
    chk("R2", "mad unchanged in normal mode", mad_o, 6'd1);
  endtask

  task automatic t_read();
    bus_data_i = 32'h7ABC_0001;
    chk("R1", "idle cs", cs_o, 4'hF);
    start_rd_i = 1; tick(); start_rd_i = 0;
    chk("R4", "read word0 busy", busy_o, 1);
    chk("R4", "read word0 bs", bs_o, 4'h1);
    chk("R4", "read word0 gpl", gpl_o, 6'h0F);
    tick();
    chk("R2", "read word1 not overwritten", bs_o, 4'h2);
    tick();
    chk("R4", "read word2 bs", bs_o, 4'h3);
    chk("R9", "res_valid", res_valid_o, 1);
    chk("R9", "res_data", res_data_o, 32'h7ABC_0001);
    chk("R9", "hit on msb 0", res_hit_o, 1);
    tick();
    chk("R6", "read done", done_o, 1);
    chk("R6", "read done kind", done_wr_o, 0);
    chk("R6", "read busy low", busy_o, 0);
    chk("R9", "res_valid one cycle", res_valid_o, 0);
    chk("R1", "cs idle after", cs_o, 4'hF);
    tick();
    chk("R6", "done one cycle", done_o, 0);
  endtask

  task automatic t_write();
    start_wr_i = 1; tick(); start_wr_i = 0;
    chk("R4", "write word0 cs", cs_o, 4'h0);
    tick();
    chk("R4", "write word1 cs", cs_o, 4'hC);
    tick();
    chk("R6", "write done", done_o, 1);
    chk("R6", "write done kind", done_wr_o, 1);
    chk("R6", "write busy low", busy_o, 0);
  endtask

  task automatic t_wait();
    set_mode(2'b00, 1, 0, 6'd0);
    bus_data_i = 32'h8000_00AA;
    start_rd_i = 1; tick(); start_rd_i = 0;
    chk("R5", "gpl4 forced high", gpl_o, 6'h1F);
    wait_i = 1; tick();
    chk("R5", "frozen word0 a", bs_o, 4'h1);
    tick();
    chk("R5", "frozen word0 b", bs_o, 4'h1);
    wait_i = 0; tick();
    chk("R5", "advance to word1", bs_o, 4'h2);
    wait_i = 1; tick();
    chk("R5", "frozen capture word", bs_o, 4'h2);
    chk("R9", "no capture while stalled", res_valid_o, 0);
    wait_i = 0; tick();
    chk("R9", "capture after release", res_valid_o, 1);
    chk("R9", "miss on msb 1", res_hit_o, 0);
    chk("R9", "captured data", res_data_o, 32'h8000_00AA);
    wait_i = 1; tick();
    chk("R5", "last word frozen bs", bs_o, 4'h3);
    chk("R5", "no done while frozen", done_o, 0);
    chk("R5", "busy while frozen", busy_o, 1);
    wait_i = 0; tick();
    chk("R6", "done after release", done_o, 1);
    chk("R6", "idle after release", busy_o, 0);
  endtask

  task automatic t_pending();
    set_mode(2'b00, 0, 0, 6'd0);
    start_rd_i = 1; tick();
    start_wr_i = 1; tick();
    start_rd_i = 0; start_wr_i = 0;
    chk("R7", "read still running", bs_o, 4'h2);
    tick(); tick();
    chk("R7", "read ended", done_o, 1);
    chk("R7", "write launched back to back", cs_o, 4'h0);
    chk("R7", "busy kept", busy_o, 1);
    tick();
    chk("R7", "write word1", cs_o, 4'hC);
    tick();
    chk("R7", "write done kind", done_wr_o, 1);
    chk("R7", "held read launched", bs_o, 4'h1);
    tick(); tick(); tick();
    chk("R7", "held read done", done_o, 1);
    chk("R7", "idle at end", busy_o, 0);
  endtask

  task automatic t_atomic();
    set_mode(2'b00, 0, 1, 6'd0);
    start_wr_i = 1; tick();
    chk("R8", "write word0", cs_o, 4'h0);
    tick();
    start_wr_i = 0;
    tick();
    chk("R8", "write done", done_wr_o, 1);
    chk("R8", "chained read word0", bs_o, 4'h1);
    chk("R8", "chained read cs", cs_o, 4'hF);
    tick(); tick(); tick();
    chk("R8", "chained read done kind", done_wr_o, 0);
    chk("R8", "held write after chain", cs_o, 4'h0);
    for (int i = 0; i < 12 && busy_o; i++) tick();
    chk("R8", "drains to idle", busy_o, 0);
    set_mode(2'b00, 0, 0, 6'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R4 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    t_reset();
    t_program();
    t_read();
    t_write();
    t_wait();
    t_pending();
    t_atomic();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule